// File: doc/BRIEF.md
# Priority-Level Interrupt Acceptance Controller

This block gathers maskable interrupt requests from a set of sources and decides, cycle by cycle, whether one of them may be taken by the processor core. Each source owns a request latch and a software-programmed priority level. A source is eligible only when three things are true together. The global disable flag must be clear. Its request must be pending. Its level must be strictly above the processor's current priority level, which the core supplies as an input.

When the core signals that it is ready and at least one source is eligible, the block issues a one-cycle accept strobe. The winning source index and its level are registered with the strobe, and the winner's request latch is cleared at the same time. A small register window lets software write and read the priority levels, the request bits and the disable flag. Selected external sources can be switched to level sense. In that mode the live input level stands in for the latch.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After reset the disable flag (address 16, bit 0) reads 1, every priority level (addresses 0..7) reads 0, every request bit (addresses 8..15, bit 0) reads 0, and `acc_o` is 0.
- R2: A one-cycle pulse on `src_evt_i[i]` sets request bit i. The bit stays 1 until source i is accepted, and it reads 0 after the accepting edge.
- R3: Writing address 8+i with data bit 0 equal to 1 or 0 sets or clears request bit i. The written value reads back.
- R4: While the disable flag is 1, no request is accepted, and pending request bits remain 1.
- R5: A source is eligible only when its level is strictly greater than `cpu_ipl_i`. A level of 0 is never eligible.
- R6: An accept happens at a clock edge only if all of these hold at that edge: the disable flag is 0, `core_rdy_i` is 1, and some source is both pending and eligible by level. `acc_o` rises one cycle after that edge.
- R7: Sources 3..7 map to external inputs 0..4. When `ext_lsense_i[k]` is 1, the pending condition of source 3+k is `ext_live_i[k]`, and its request bit is ignored. Sources 0..2 have no level-sense mode.
- R8: Writing a priority level, a request bit or the disable flag changes no other register.
- R9: Among eligible pending sources, the one with the highest level wins. Equal levels go to the lowest index. The winner's index and level appear on `acc_idx_o` and `acc_lvl_o` while `acc_o` is 1.
- R10: `acc_o` is high for exactly one cycle. No accept is decided at the edge where `acc_o` is already 1, even if `core_rdy_i` stays high.
- R11: A request event on a source in the same cycle as that source's acceptance leaves the bit at 1. An event in the same cycle as a software write of 0 also leaves the bit at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt_i | input | 8 | Per-source request event pulses |
| ext_live_i | input | 5 | Live levels of external inputs feeding sources 3..7 |
| ext_lsense_i | input | 5 | Level-sense mode select for sources 3..7 |
| cpu_ipl_i | input | 3 | Processor current priority level |
| core_rdy_i | input | 1 | Core can take an interrupt this cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register write address |
| wr_data_i | input | 3 | Register write data |
| rd_addr_i | input | 5 | Register read address |
| rd_data_o | output | 3 | Register read data (combinational) |
| acc_o | output | 1 | Accept strobe |
| acc_idx_o | output | 3 | Accepted source index |
| acc_lvl_o | output | 3 | Accepted source level |

## Verification
Two things can hit the same request bit in the same cycle: the clear that comes with acceptance and the setting done by a new request event or a software write. The bench provokes this by pulsing a source's event line in exactly the cycle where that source wins. A second test pulses it in the cycle of a software write of 0. It then reads the bit back and expects 1 in both cases. Around these tests, a sweep over 64 arithmetic mixes of levels, request patterns and processor levels compares each accept decision and winner against a model computed in the bench.

// File: rtl/irq_acc_pkg.sv
// Package irq_acc_pkg
// Shared level width and type for the interrupt acceptance controller.
// Assumes levels are small unsigned integers where 0 means "off".
package irq_acc_pkg;
    localparam int LVL_W = 3;
    typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_src_slot.sv
// Module irq_src_slot
// One interrupt source: a request latch, its priority level register, and
// the pending/eligible decision against the processor level.
// Assumes: evt_i is a one-cycle pulse. clr_i is asserted only at the edge
// where this source is accepted. If HAS_LSENSE is 0, lsense_i and live_i
// are ignored.
module irq_src_slot
    import irq_acc_pkg::*;
#(
    parameter bit HAS_LSENSE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic lvl_wr_i,
    input  logic req_wr_i,
    input  lvl_t wr_data_i,
    input  logic clr_i,
    input  logic lsense_i,
    input  logic live_i,
    input  lvl_t cpu_ipl_i,
    output logic req_o,
    output lvl_t lvl_o,
    output logic qual_o
);
    logic req_q;
    lvl_t lvl_q;
    logic pend;

    // Request latch: the accept clear yields to a software write, and both yield to a new event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (evt_i) begin
            req_q <= 1'b1;
        end else if (req_wr_i) begin
            req_q <= wr_data_i[0];
        end else if (clr_i) begin
            req_q <= 1'b0;
        end
    end

    // Priority level register, written only by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else if (lvl_wr_i) begin
            lvl_q <= wr_data_i;
        end
    end

    // Pending condition: the live input in level-sense mode, otherwise the latch.
    generate
        if (HAS_LSENSE) begin : g_ls
            assign pend = lsense_i ? live_i : req_q;
        end else begin : g_edge
            assign pend = req_q;
        end
    endgenerate

    // Eligibility: pending, and the level strictly above the processor level.
    assign qual_o = pend && (lvl_q > cpu_ipl_i);
    assign req_o  = req_q;
    assign lvl_o  = lvl_q;

    // R11: an event always leaves the latch set.
    a_r11_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> req_o);
    // R2: an accept with no competing write or event clears the latch.
    a_r2_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !evt_i && !req_wr_i) |=> !req_o);
    // R8: the level changes only through its own write.
    a_r8_lvl_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_wr_i |=> $stable(lvl_o));
endmodule

// File: rtl/irq_winner_sel.sv
// Module irq_winner_sel
// Combinational choice among eligible sources: the highest level wins, and
// equal levels go to the lowest index.
// Assumes an eligible source always has a level of at least 1, because it
// must exceed a processor level of 0 or more.
module irq_winner_sel
    import irq_acc_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0]       qual_i,
    input  lvl_t [N_SRC-1:0]       lvl_i,
    output logic                   any_o,
    output logic [IDX_W-1:0]       idx_o,
    output lvl_t                   lvl_o
);
    // Linear scan: a strict compare keeps the earliest index on a tie.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        lvl_o = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (qual_i[i] && (!any_o || lvl_i[i] > lvl_o)) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
                lvl_o = lvl_i[i];
            end
        end
    end
endmodule

// File: rtl/irq_accept_ctrl.sv
// Module irq_accept_ctrl
// Top of the maskable interrupt acceptance controller. It holds the global
// disable flag and the register window, and builds one slot per source.
// When the core is ready it issues a registered one-cycle accept and clears
// the winner's latch.
// Register map: addresses 0..N_SRC-1 hold the levels, N_SRC..2*N_SRC-1 hold
// the request bits (bit 0), and 2*N_SRC holds the disable flag (bit 0).
// Assumes the processor level is updated outside this block after an accept.
module irq_accept_ctrl
    import irq_acc_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int EXT_LO = 3,
    parameter int N_EXT  = 5,
    parameter int ADDR_W = 5,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_evt_i,
    input  logic [N_EXT-1:0]  ext_live_i,
    input  logic [N_EXT-1:0]  ext_lsense_i,
    input  logic [LVL_W-1:0]  cpu_ipl_i,
    input  logic              core_rdy_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [LVL_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [LVL_W-1:0]  rd_data_o,
    output logic              acc_o,
    output logic [IDX_W-1:0]  acc_idx_o,
    output logic [LVL_W-1:0]  acc_lvl_o
);
    localparam int REQ_BASE = N_SRC;
    localparam int DIS_ADDR = 2 * N_SRC;

    logic                dis_q;
    logic [N_SRC-1:0]    req;
    lvl_t [N_SRC-1:0]    lvl;
    logic [N_SRC-1:0]    qual;
    logic                win_any;
    logic [IDX_W-1:0]    win_idx;
    lvl_t                win_lvl;
    logic                go;
    logic                acc_q;
    logic [IDX_W-1:0]    idx_q;
    lvl_t                lvl_acc_q;

    // Accept decision: the flag is clear, the core is ready, the previous cycle was no accept, and some source is eligible.
    assign go = !dis_q && core_rdy_i && !acc_q && win_any;

    // Per-source slots; only the external range gets the level-sense variant.
    generate
        for (genvar i = 0; i < N_SRC; i++) begin : g_src
            localparam bit IS_EXT = (i >= EXT_LO) && (i < EXT_LO + N_EXT);
            logic ls, live;
            if (IS_EXT) begin : g_ext
                assign ls   = ext_lsense_i[i - EXT_LO];
                assign live = ext_live_i[i - EXT_LO];
            end else begin : g_int
                assign ls   = 1'b0;
                assign live = 1'b0;
            end
            irq_src_slot #(.HAS_LSENSE(IS_EXT)) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .evt_i     (src_evt_i[i]),
                .lvl_wr_i  (wr_en_i && wr_addr_i == ADDR_W'(i)),
                .req_wr_i  (wr_en_i && wr_addr_i == ADDR_W'(REQ_BASE + i)),
                .wr_data_i (wr_data_i),
                .clr_i     (go && win_idx == IDX_W'(i)),
                .lsense_i  (ls),
                .live_i    (live),
                .cpu_ipl_i (cpu_ipl_i),
                .req_o     (req[i]),
                .lvl_o     (lvl[i]),
                .qual_o    (qual[i])
            );
        end
    endgenerate

    irq_winner_sel #(.N_SRC(N_SRC)) u_sel (
        .qual_i (qual),
        .lvl_i  (lvl),
        .any_o  (win_any),
        .idx_o  (win_idx),
        .lvl_o  (win_lvl)
    );

    // Global disable flag: comes up set, and only its own address changes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q <= 1'b1;
        end else if (wr_en_i && wr_addr_i == ADDR_W'(DIS_ADDR)) begin
            dis_q <= wr_data_i[0];
        end
    end

    // Output registers: the strobe, index and level are captured together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= 1'b0;
            idx_q     <= '0;
            lvl_acc_q <= '0;
        end else begin
            acc_q <= go;
            if (go) begin
                idx_q     <= win_idx;
                lvl_acc_q <= win_lvl;
            end
        end
    end

    // Read mux over the register window.
    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (rd_addr_i == ADDR_W'(i))            rd_data_o = lvl[i];
            if (rd_addr_i == ADDR_W'(REQ_BASE + i)) rd_data_o = LVL_W'(req[i]);
        end
        if (rd_addr_i == ADDR_W'(DIS_ADDR)) rd_data_o = LVL_W'(dis_q);
    end

    assign acc_o     = acc_q;
    assign acc_idx_o = idx_q;
    assign acc_lvl_o = lvl_acc_q;

    // R10: the strobe never lasts two cycles.
    a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o |=> !acc_o);
    // R6: an accept follows an edge where the core was ready.
    a_r6_core_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_o) |-> $past(core_rdy_i));
    // R4: an accept follows an edge where the disable flag was clear.
    a_r4_not_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_o) |-> $past(!dis_q));
    // R5: the accepted level is strictly above the processor level of the deciding edge.
    a_r5_level_above: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_o) |-> (acc_lvl_o > $past(cpu_ipl_i)));
endmodule

// File: tb/irq_accept_ctrl_tb.sv
`timescale 1ns/1ps
module irq_accept_ctrl_tb;
    localparam int N = 8;
    localparam int REQB = 8;
    localparam int DISA = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src_evt = '0;
    logic [4:0] ext_live = '0;
    logic [4:0] ext_ls = '0;
    logic [2:0] ipl = '0;
    logic       rdy = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [2:0] wr_data = '0;
    logic [4:0] rd_addr = '0;
    logic [2:0] rd_data;
    logic       acc;
    logic [2:0] acc_idx;
    logic [2:0] acc_lvl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_accept_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_evt_i(src_evt), .ext_live_i(ext_live),
        .ext_lsense_i(ext_ls), .cpu_ipl_i(ipl), .core_rdy_i(rdy),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .acc_o(acc),
        .acc_idx_o(acc_idx), .acc_lvl_o(acc_lvl)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = 3'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        rd_addr = 5'(a);
        #1;
        v = int'(rd_data);
    endtask

    // Hold the core ready across one edge, then sample the registered outputs.
    task automatic fire();
        @(negedge clk);
        rdy = 1'b1;
        @(negedge clk);
        rdy = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        int lv[8];
        int rq[8];
        int best;
        int bl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(DISA, v); chk("R1 disable flag", v, 1);
        for (int i = 0; i < N; i++) begin
            rd(i, v); chk("R1 level", v, 0);
            rd(REQB + i, v); chk("R1 request", v, 0);
        end
        chk("R1 acc", int'(acc), 0);

        // R3 software write of request bits
        wr(REQB + 5, 1); rd(REQB + 5, v); chk("R3 write 1", v, 1);
        wr(REQB + 5, 0); rd(REQB + 5, v); chk("R3 write 0", v, 0);

        // R4 disabled: nothing is accepted and the bits stay pending
        wr(1, 6); wr(REQB + 1, 1); ipl = 3'd0;
        fire(); chk("R4 no accept while disabled", int'(acc), 0);
        rd(REQB + 1, v); chk("R4 request kept", v, 1);
        wr(REQB + 1, 0); wr(1, 0);

        // R8 independence of registers
        wr(2, 5);
        rd(DISA, v); chk("R8 flag after level write", v, 1);
        rd(REQB + 2, v); chk("R8 req after level write", v, 0);
        rd(3, v); chk("R8 neighbour level", v, 0);
        wr(REQB + 2, 1); rd(2, v); chk("R8 level after req write", v, 5);
        wr(DISA, 0); rd(2, v); chk("R8 level after flag write", v, 5);
        rd(REQB + 2, v); chk("R8 req after flag write", v, 1);
        wr(REQB + 2, 0); wr(2, 0);

        // R2 edge event sets the latch, and the accept clears it
        wr(0, 4);
        @(negedge clk); src_evt[0] = 1'b1; @(negedge clk); src_evt[0] = 1'b0;
        rd(REQB, v); chk("R2 event sets", v, 1);
        @(negedge clk); rd(REQB, v); chk("R2 stays set", v, 1);
        fire(); chk("R2 accept", int'(acc), 1); chk("R2 idx", int'(acc_idx), 0);
        rd(REQB, v); chk("R2 cleared on accept", v, 0);
        wr(0, 0);

        // R5 R6 R9 sweep over arithmetic mixes
        for (int t = 0; t < 64; t++) begin
            for (int i = 0; i < N; i++) begin
                lv[i] = (t * 3 + i * 5 + t / 8) % 8;
                rq[i] = ((t * 37 + 11) >> i) & 1;
                wr(i, lv[i]);
                wr(REQB + i, rq[i]);
            end
            ipl = 3'(t % 8);
            best = -1; bl = -1;
            for (int i = 0; i < N; i++)
                if (rq[i] == 1 && lv[i] > int'(ipl) && lv[i] > bl) begin
                    best = i; bl = lv[i];
                end
            fire();
            chk("R6 accept decision", int'(acc), best >= 0 ? 1 : 0);
            if (best >= 0) begin
                chk("R9 winner index", int'(acc_idx), best);
                chk("R5 winner level", int'(acc_lvl), bl);
                rq[best] = 0;
            end
            for (int i = 0; i < N; i++) begin
                rd(REQB + i, v); chk("R2 request after sweep step", v, rq[i]);
            end
        end
        for (int i = 0; i < N; i++) begin wr(i, 0); wr(REQB + i, 0); end
        ipl = 3'd0;

        // R5 level 0 never eligible
        wr(6, 0); wr(REQB + 6, 1); fire();
        chk("R5 level zero", int'(acc), 0);
        wr(REQB + 6, 0);

        // R6 not ready: nothing is accepted
        wr(1, 7); wr(REQB + 1, 1);
        @(negedge clk); @(negedge clk);
        chk("R6 no accept without ready", int'(acc), 0);

        // R10 ready held: the accept pattern is 1, 0, 1
        wr(0, 2); wr(REQB, 1);
        @(negedge clk); rdy = 1'b1;
        @(negedge clk); chk("R10 first pulse", int'(acc), 1); chk("R10 first idx", int'(acc_idx), 1);
        @(negedge clk); chk("R10 gap", int'(acc), 0);
        @(negedge clk); chk("R10 second pulse", int'(acc), 1); chk("R10 second idx", int'(acc_idx), 0);
        rdy = 1'b0;
        @(negedge clk);
        wr(0, 0); wr(1, 0);

        // R11 event in the accept cycle keeps the bit set
        wr(2, 7); wr(REQB + 2, 1);
        @(negedge clk); rdy = 1'b1; src_evt[2] = 1'b1;
        @(negedge clk); rdy = 1'b0; src_evt[2] = 1'b0;
        chk("R11 accepted", int'(acc), 1); chk("R11 idx", int'(acc_idx), 2);
        rd(REQB + 2, v); chk("R11 bit kept after accept", v, 1);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(REQB + 2); wr_data = 3'd0; src_evt[2] = 1'b1;
        @(negedge clk); wr_en = 1'b0; src_evt[2] = 1'b0;
        rd(REQB + 2, v); chk("R11 event beats write of 0", v, 1);
        wr(REQB + 2, 0); wr(2, 0);

        // R7 level sense on source 4 (external input 1)
        wr(4, 5); ext_ls[1] = 1'b1; ext_live[1] = 1'b1;
        fire(); chk("R7 live level accepted", int'(acc), 1); chk("R7 idx", int'(acc_idx), 4);
        ext_live[1] = 1'b0; wr(REQB + 4, 1);
        fire(); chk("R7 latch ignored", int'(acc), 0);
        ext_ls[1] = 1'b0;
        fire(); chk("R7 edge mode uses latch", int'(acc), 1);
        // R7 source 1 has no level-sense mode
        wr(4, 0); wr(1, 5); ext_ls = 5'b11111; ext_live = 5'b11111;
        fire(); chk("R7 internal source not level sensed", int'(acc), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule